// File: doc/BRIEF.md
# SPI Command Frame Receiver

This block is the serial slave front end of a four-channel, register-programmed device. While the active-low select is held low, it samples serial data on every rising edge of the serial clock. Bits arrive most significant bit first. It counts them, and when the select returns high it checks the count. If the frame is whole, it splits the captured 16-bit word into a command code, an address and a data byte. It then reports the result as a one-cycle strobe in the system clock domain. Write commands become per-channel write enables. Restore commands become reload requests for the surrounding logic.

Frames may be any whole number of 16-bit words. Longer frames pass their earlier bits out of the serial output to the next device in a daisy chain, and only the last word is decoded. A select pulse with no clock edges re-runs the most recently decoded command. An active-low write-protect input suppresses channel writes but lets restore requests through. A falling edge on the active-low preset input requests a reload of every channel. All pin inputs are resynchronised to the system clock, so the serial clock must be slow compared with it.

Top module: `spi_cmd_rx`

## Requirements
- R1: A frame of exactly 16 bits is shifted in MSB first and decoded as code = bits 15:12, address = bits 11:8, data = bits 7:0. Decoding happens only after `cs_n_i` rises. `cmd_vld_o` is high for exactly one cycle: the third rising `clk` edge after the `cs_n_i` rise.
- R2: A frame of 32 bits is valid, and the fields come from the last 16 bits shifted in.
- R3: A frame whose bit count is not a whole multiple of 16 produces no strobe, no write and no reload. This includes counts that are not multiples of four, such as 15, 17 and 6, and counts such as 8. The stored replay command is left unchanged.
- R4: After a valid frame, a select low pulse with no clock edges issues the stored command again, with `cmd_replay_o` = 1 and the same fields. Its write or reload is carried out again.
- R5: After reset and before any valid frame, a select pulse with no clock edges produces no strobe.
- R6: Code 0xB with an address below 4 raises `wr_en_o[address]` alongside the strobe, with `wr_data_o` = data bits 5:0. With address 4 or higher, no write enable rises.
- R7: While `wp_n_i` is low, no write enable rises, but the strobe and its fields are still reported.
- R8: Code 0x1 raises `ld_o` with `ld_all_o` = 0 and `ld_addr_o` = address. Code 0x8 raises `ld_o` with `ld_all_o` = 1. Both happen whatever the level of `wp_n_i`.
- R9: A falling edge on `pr_n_i` raises `ld_o` and `ld_all_o` for one cycle, on the third rising `clk` edge after the fall, with no command strobe.
- R10: `sdo_oe_o` is 1 while the select is low and 0 while it is high, each three `clk` edges after the pin changes. `sdo_o` shows the bit shifted in 16 serial clocks earlier.
- R11: During and right after reset, every strobe, every enable and `sdo_oe_o` are 0.
- R12: Both serial clock polarities work, idle low and idle high. Data is always taken on the rising serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock pin |
| cs_n_i | input | 1 | Active-low select pin |
| sdi_i | input | 1 | Serial data in |
| wp_n_i | input | 1 | Active-low write protect |
| pr_n_i | input | 1 | Active-low preset (reload all) |
| sdo_o | output | 1 | Serial data out to the next device |
| sdo_oe_o | output | 1 | Serial output drive enable (0 = released) |
| cmd_vld_o | output | 1 | One-cycle decoded command strobe |
| cmd_replay_o | output | 1 | Strobe was caused by a clockless select pulse |
| cmd_code_o | output | 4 | Decoded command code |
| cmd_addr_o | output | 4 | Decoded address |
| cmd_data_o | output | 8 | Decoded data byte |
| wr_en_o | output | 4 | One-hot channel write enable pulse |
| wr_data_o | output | 6 | Value to write into the channel |
| ld_o | output | 1 | Reload-from-storage request pulse |
| ld_all_o | output | 1 | Reload request covers every channel |
| ld_addr_o | output | 4 | Channel to reload when not all |

## Verification
Every pin goes through a two-flop synchroniser and then an edge-detect flop. As a result, the command strobe, the write and reload pulses and the change of `sdo_oe_o` all land on the third rising `clk` edge after the pin event, and a new `sdo_o` bit appears by the third edge after a serial clock rise. The bench changes pins on falling `clk` edges and counts rising edges from there. It checks that the strobe is still low after the second edge, samples the fields after the third, and checks again after the fourth to confirm a single-cycle pulse. Serial bits are held for three system clocks on each side of the serial clock rise, so the sampled data is always settled.

// File: rtl/spi_cmd_rx_pkg.sv
package spi_cmd_rx_pkg;
  localparam int CODE_W = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [CODE_W-1:0] OP_LOAD_ONE = 4'h1;
  localparam logic [CODE_W-1:0] OP_LOAD_ALL = 4'h8;
  localparam logic [CODE_W-1:0] OP_WRITE    = 4'hB;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/spi_cmd_rx_sync.sv
module spi_cmd_rx_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_cmd_rx_shift.sv
module spi_cmd_rx_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               bit_stb,
  input  logic               bit_in,
  input  logic               close,
  output logic [FRAME_W-1:0] word_o,
  output logic               sdo_o,
  output logic               whole_o,
  output logic               empty_o
);
  localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               any_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
      any_q <= 1'b0;
    end else if (sel && bit_stb) begin
      sh_q  <= {sh_q[FRAME_W-2:0], bit_in};
      cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      any_q <= 1'b1;
    end else if (!sel) begin
      cnt_q <= '0;
      any_q <= 1'b0;
    end
  end

  assign word_o  = sh_q;
  assign sdo_o   = sh_q[FRAME_W-1];
  assign whole_o = close && any_q && (cnt_q == '0);
  assign empty_o = close && !any_q;
endmodule

// File: rtl/spi_cmd_rx_exec.sv
module spi_cmd_rx_exec
  import spi_cmd_rx_pkg::*;
#(
  parameter int NCH = 4,
  parameter int KEEP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_ok,
  input  logic              frame_none,
  input  cmd_t              word,
  input  logic              wp_ok,
  input  logic              preset,
  output logic              vld_o,
  output logic              replay_o,
  output cmd_t              cmd_o,
  output logic [NCH-1:0]    wr_en_o,
  output logic [KEEP_W-1:0] wr_data_o,
  output logic              ld_o,
  output logic              ld_all_o,
  output logic [ADDR_W-1:0] ld_addr_o
);
  localparam int AIDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  cmd_t mem_q;
  logic mem_v_q;
  logic fire;
  cmd_t src;

  always_comb begin
    fire = frame_ok || (frame_none && mem_v_q);
    src  = frame_ok ? word : mem_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q     <= '0;
      mem_v_q   <= 1'b0;
      vld_o     <= 1'b0;
      replay_o  <= 1'b0;
      cmd_o     <= '0;
      wr_en_o   <= '0;
      wr_data_o <= '0;
      ld_o      <= 1'b0;
      ld_all_o  <= 1'b0;
      ld_addr_o <= '0;
    end else begin
      vld_o    <= fire;
      wr_en_o  <= '0;
      ld_o     <= 1'b0;
      ld_all_o <= 1'b0;
      if (fire) begin
        replay_o <= !frame_ok;
        cmd_o    <= src;
        if (src.code == OP_WRITE && 32'(src.addr) < NCH && wp_ok) begin
          wr_en_o[src.addr[AIDX_W-1:0]] <= 1'b1;
          wr_data_o <= src.data[KEEP_W-1:0];
        end
        if (src.code == OP_LOAD_ONE) begin
          ld_o      <= 1'b1;
          ld_addr_o <= src.addr;
        end
        if (src.code == OP_LOAD_ALL) begin
          ld_o     <= 1'b1;
          ld_all_o <= 1'b1;
        end
      end
      if (frame_ok) begin
        mem_q   <= word;
        mem_v_q <= 1'b1;
      end
      if (preset) begin
        ld_o     <= 1'b1;
        ld_all_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_rx_pkg::*;
#(
  parameter int NCH = 4,
  parameter int KEEP_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              sdi_i,
  input  logic              wp_n_i,
  input  logic              pr_n_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              cmd_vld_o,
  output logic              cmd_replay_o,
  output logic [CODE_W-1:0] cmd_code_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic [NCH-1:0]    wr_en_o,
  output logic [KEEP_W-1:0] wr_data_o,
  output logic              ld_o,
  output logic              ld_all_o,
  output logic [ADDR_W-1:0] ld_addr_o
);
  localparam int FRAME_W = $bits(cmd_t);
  localparam int PIN_W = 5;
  // pin order: 0 sclk, 1 sdi, 2 cs_n, 3 wp_n, 4 pr_n
  localparam logic [PIN_W-1:0] PIN_IDLE = 5'b11100;

  logic [PIN_W-1:0] pin_s, pin_d;
  logic sclk_rise, cs_rise, pr_fall, sel_s, wp_ok_s;
  logic whole, empty;
  logic [FRAME_W-1:0] word_w;
  cmd_t cmd_w;
  logic sdo_oe_q;

  spi_cmd_rx_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst),
    .d({pr_n_i, wp_n_i, cs_n_i, sdi_i, sclk_i}),
    .q(pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_d    <= PIN_IDLE;
      sdo_oe_q <= 1'b0;
    end else begin
      pin_d    <= pin_s;
      sdo_oe_q <= !pin_s[2];
    end
  end

  assign sclk_rise = pin_s[0] && !pin_d[0];
  assign cs_rise   = pin_s[2] && !pin_d[2];
  assign pr_fall   = !pin_s[4] && pin_d[4];
  assign sel_s     = !pin_s[2];
  assign wp_ok_s   = pin_s[3];

  spi_cmd_rx_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .sel(sel_s), .bit_stb(sclk_rise), .bit_in(pin_s[1]),
    .close(cs_rise), .word_o(word_w), .sdo_o(sdo_o), .whole_o(whole), .empty_o(empty)
  );

  assign cmd_w = cmd_t'(word_w);

  cmd_t cmd_q;

  spi_cmd_rx_exec #(.NCH(NCH), .KEEP_W(KEEP_W)) u_exec (
    .clk(clk), .rst(rst), .frame_ok(whole), .frame_none(empty), .word(cmd_w),
    .wp_ok(wp_ok_s), .preset(pr_fall), .vld_o(cmd_vld_o), .replay_o(cmd_replay_o),
    .cmd_o(cmd_q), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .ld_o(ld_o),
    .ld_all_o(ld_all_o), .ld_addr_o(ld_addr_o)
  );

  assign cmd_code_o = cmd_q.code;
  assign cmd_addr_o = cmd_q.addr;
  assign cmd_data_o = cmd_q.data;
  assign sdo_oe_o   = sdo_oe_q;
endmodule

// File: rtl/spi_cmd_rx_chk.sv
module spi_cmd_rx_chk
  import spi_cmd_rx_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              vld,
  input logic [CODE_W-1:0] code,
  input logic [NCH-1:0]    wr_en,
  input logic              ld,
  input logic              ld_all,
  input logic              sdo_oe,
  input logic              wp_ok
);
  // R1
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst) vld |=> !vld);
  // R10
  strobe_released_chk: assert property (@(posedge clk) disable iff (rst) vld |-> !sdo_oe);
  // R6
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_en));
  // R6
  wr_needs_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en != '0) |-> (vld && code == OP_WRITE));
  // R7
  wr_protect_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en != '0) |-> $past(wp_ok));
  // R8
  ld_all_chk: assert property (@(posedge clk) disable iff (rst) ld_all |-> ld);
endmodule

bind spi_cmd_rx spi_cmd_rx_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .vld(cmd_vld_o), .code(cmd_code_o), .wr_en(wr_en_o),
  .ld(ld_o), .ld_all(ld_all_o), .sdo_oe(sdo_oe_o), .wp_ok(wp_ok_s)
);

// File: tb/tb_spi_cmd_rx.sv
module tb_spi_cmd_rx;
  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, wp_n = 1'b1, pr_n = 1'b1;
  logic sdo, sdo_oe, vld, rep, ld, ld_all;
  logic [3:0] code, addr, wr_en, ld_addr;
  logic [7:0] data;
  logic [5:0] wr_data;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] last_w = '0;
  bit last_v = 0;

  always #10 clk = ~clk;

  spi_cmd_rx dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi), .wp_n_i(wp_n),
    .pr_n_i(pr_n), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .cmd_vld_o(vld), .cmd_replay_o(rep),
    .cmd_code_o(code), .cmd_addr_o(addr), .cmd_data_o(data), .wr_en_o(wr_en),
    .wr_data_o(wr_data), .ld_o(ld), .ld_all_o(ld_all), .ld_addr_o(ld_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_wr(input logic [15:0] w, input bit wp_ok);
    return (w[15:12] == 4'hB && w[11:8] < 4 && wp_ok) ? (4'b0001 << w[9:8]) : 4'b0000;
  endfunction

  task automatic open_cs(input bit m3);
    sclk = m3;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b, input bit m3);
    sdi = b;
    if (m3) sclk = 1'b0;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    if (!m3) sclk = 1'b0;
  endtask

  task automatic shift_word(input logic [31:0] w, input int n, input bit m3);
    for (int i = n - 1; i >= 0; i--) shift_bit(w[i], m3);
  endtask

  // raise select, check the strobe lands on the third clk edge only
  task automatic close_good(input string req, input logic [15:0] w, input bit replay);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({req, " R1 strobe early"}, vld, 1'b0);
    @(negedge clk);
    chk({req, " R1 strobe"}, vld, 1'b1);
    chk({req, " R4 replay flag"}, rep, replay);
    chk({req, " R1 fields"}, {code, addr, data}, w);
    chk({req, " R6 R7 write enable"}, wr_en, exp_wr(w, wp_n));
    if (exp_wr(w, wp_n) != 0) chk({req, " R6 write data"}, wr_data, w[5:0]);
    chk({req, " R8 reload"}, {ld, ld_all}, {w[15:12] == 4'h1 || w[15:12] == 4'h8, w[15:12] == 4'h8});
    if (w[15:12] == 4'h1) chk({req, " R8 reload addr"}, ld_addr, w[11:8]);
    chk({req, " R10 released"}, sdo_oe, 1'b0);
    @(negedge clk);
    chk({req, " R1 single cycle"}, {vld, wr_en, ld}, 6'd0);
    repeat (3) @(negedge clk);
    if (!replay) begin last_w = w; last_v = 1; end
  endtask

  task automatic close_none(input string req);
    bit bad = 0;
    cs_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (vld || wr_en != 0 || ld) bad = 1;
    end
    chk({req, " no strobe"}, bad, 1'b0);
  endtask

  task automatic replay_pulse(input string req);
    open_cs(0);
    if (last_v) close_good({req, " R4"}, last_w, 1);
    else close_none({req, " R5"});
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    chk("R11 reset outputs", {vld, wr_en, ld, ld_all, sdo_oe}, 8'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 after reset", {vld, wr_en, ld, ld_all, sdo_oe}, 8'd0);

    replay_pulse("R5 empty memory");

    open_cs(0);
    chk("R10 drive while selected", sdo_oe, 1'b1);
    shift_word(32'hB2EA, 16, 0);
    close_good("R1 R6 mode0 write", 16'hB2EA, 0);

    open_cs(1);
    shift_word(32'hB0C5, 16, 1);
    close_good("R12 mode3 write", 16'hB0C5, 0);

    replay_pulse("R4 replay");

    // 32-bit daisy frame
    open_cs(0);
    shift_word(32'hB115, 16, 0);
    for (int j = 0; j < 16; j++) begin
      chk("R10 daisy sdo", sdo, logic'((16'hB115 >> (15 - j)) & 1));
      shift_bit(logic'((16'hB33F >> (15 - j)) & 1), 0);
    end
    close_good("R2 32-bit frame", 16'hB33F, 0);

    open_cs(0); shift_word(32'h1234, 15, 0); close_none("R3 count 15");
    open_cs(1); shift_word(32'h12345, 17, 1); close_none("R3 count 17");
    open_cs(0); shift_word(32'h3F, 6, 0); close_none("R3 count 6");
    open_cs(0); shift_word(32'hB1, 8, 0); close_none("R3 count 8");
    replay_pulse("R3 memory kept");

    wp_n = 1'b0; repeat (4) @(negedge clk);
    open_cs(0); shift_word(32'hB11F, 16, 0); close_good("R7 protected write", 16'hB11F, 0);
    open_cs(0); shift_word(32'h1300, 16, 0); close_good("R8 reload one under protect", 16'h1300, 0);
    open_cs(1); shift_word(32'h8000, 16, 1); close_good("R8 reload all under protect", 16'h8000, 0);
    wp_n = 1'b1; repeat (4) @(negedge clk);

    open_cs(0); shift_word(32'hB515, 16, 0); close_good("R6 address out of range", 16'hB515, 0);

    pr_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 preset early", ld, 1'b0);
    @(negedge clk);
    chk("R9 preset reload", {ld, ld_all, vld}, 3'b110);
    pr_n = 1'b1;
    @(negedge clk);
    chk("R9 preset single cycle", ld, 1'b0);
    repeat (3) @(negedge clk);

    for (int it = 0; it < 60; it++) begin
      int kind;
      bit m3;
      logic [31:0] w;
      kind = $urandom % 6;
      m3 = $urandom % 2;
      wp_n = ($urandom % 4) != 0;
      repeat (4) @(negedge clk);
      w = $urandom;
      case ($urandom % 4)
        0: w[15:12] = 4'hB;
        1: w[15:12] = 4'h1;
        2: w[15:12] = 4'h8;
        default: ;
      endcase
      if (kind < 4) begin
        int n;
        n = (kind == 3) ? 32 : 16;
        open_cs(m3); shift_word(w, n, m3); close_good("R1 R2 R12 random frame", w[15:0], 0);
      end else if (kind == 4) begin
        int n;
        n = 1 + ($urandom % 30);
        if (n % 16 == 0) n = n + 1;
        open_cs(m3); shift_word(w, n, m3); close_none("R3 random bad count");
      end else begin
        replay_pulse("R4 random replay");
      end
    end
    wp_n = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule